// File: doc/BRIEF.md
# Illegal Instruction Trap Unit

This block watches every instruction word that a small 32-bit RISC-V core fetches. It decides whether the word belongs to a reduced legal subset. The subset holds the base integer instructions, the 16-bit compressed forms and the multiply-only part of the M extension. Several classes are rejected: divide and remainder, everything under the SYSTEM major opcode (CSR accesses, counters, environment calls, privilege returns, WFI), the memory-ordering opcode, and every major opcode that is not named as legal, such as floating-point and atomics.

A rejected word that arrives with the valid strobe high sets a sticky trap. One clock later the unit raises `halt` and `trap`, and both stay high until the active-low reset is applied. No other input clears them. While the core runs, a green status light stays on. Once it halts, green and blue go dark and red blinks. The blink rate comes from a power-of-two prescaler. The block has no interrupt input and no interrupt logic.

Top module: `insn_guard`

## Requirements
- R1: Base integer words are legal and leave `halt` low. This covers opcode 0110011 with funct7 0000000 (or 0100000 when funct3 is 000 or 101), 0010011, loads 0000011, stores 0100011, branches 1100011, JAL 1101111, JALR 1100111 with funct3 000, LUI 0110111 and AUIPC 0010111.
- R2: Opcode 0110011 with funct7 0000001 and funct3 000 to 011 (the four multiplies) is legal.
- R3: Opcode 0110011 with funct7 0000001 and funct3 100 to 111 (divide and remainder) is illegal.
- R4: Every word with opcode 1110011 is illegal, whatever its other fields hold.
- R5: Every word with opcode 0001111 (fence and instruction fence) is illegal.
- R6: Any major opcode that R1 and R2 do not list is illegal. Examples are 0000111 (floating load) and 0101111 (atomics).
- R7: When bits [1:0] of the word are not 2'b11, only bits [15:0] are decoded, as a compressed instruction, and bits [31:16] are ignored. Supported compressed forms are legal. Examples: 0x0505 (add immediate), 0x4188 (word load), 0x0040 (stack-pointer add with a nonzero immediate).
- R8: These compressed words are illegal: the all-zero halfword 0x0000, the stack-pointer add form (quadrant 00, funct3 000) with a zero 8-bit immediate such as 0x0004, the breakpoint 0x9002, and the compressed floating-point loads and stores such as 0x2000.
- R9: An illegal word sampled with `insn_vld` high raises `halt` and `trap` at the next rising clock edge. An illegal word presented with `insn_vld` low has no effect.
- R10: Once raised, `halt` and `trap` stay high through any later input until `rst_n` is driven low.
- R11: While running, `led_g` is 1 and `led_r` and `led_b` are 0. While halted, `led_g` and `led_b` are 0. In that state `led_r` is 1 for 2^BLINK_LOG2 clocks starting in the cycle `halt` rises, then 0 for 2^BLINK_LOG2 clocks, and the pattern repeats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low power-on reset, the only way to clear a trap |
| insn_vld | input | 1 | High when `insn_word` holds a fetched instruction |
| insn_word | input | 32 | Fetched instruction; a compressed instruction sits in bits [15:0] |
| halt | output | 1 | Stops the core; sticky |
| trap | output | 1 | Sticky illegal-instruction flag |
| led_r | output | 1 | Red status drive, blinks while halted |
| led_g | output | 1 | Green status drive, on while running |
| led_b | output | 1 | Blue status drive, held off |

## Verification
Legality is decided combinationally and registered once, so `halt` and `trap` are due one edge after the valid strobe. The bench drives inputs on the falling edge and reads the outputs on the next falling edge, which makes the trap result visible in the first sample after the word. The LED outputs follow the same register with no further delay. The bench therefore expects `led_r` high in that first sample. It runs the prescaler at 2^3 and counts falling edges from that first sample: red must be on at samples 0 and 7, off at 8 and 15, and back on at 16. Stickiness is checked by holding legal traffic for twenty further cycles and then reading the outputs.

// File: rtl/insn_guard_pkg.sv
package insn_guard_pkg;
   // major opcodes, bits [6:0]
   localparam logic [6:0] OPC_LOAD   = 7'b0000011;
   localparam logic [6:0] OPC_MEMORD = 7'b0001111;
   localparam logic [6:0] OPC_OPIMM  = 7'b0010011;
   localparam logic [6:0] OPC_AUIPC  = 7'b0010111;
   localparam logic [6:0] OPC_STORE  = 7'b0100011;
   localparam logic [6:0] OPC_OP     = 7'b0110011;
   localparam logic [6:0] OPC_LUI    = 7'b0110111;
   localparam logic [6:0] OPC_BRANCH = 7'b1100011;
   localparam logic [6:0] OPC_JALR   = 7'b1100111;
   localparam logic [6:0] OPC_JAL    = 7'b1101111;
   localparam logic [6:0] OPC_SYS    = 7'b1110011;

   localparam logic [6:0] F7_BASE = 7'b0000000;
   localparam logic [6:0] F7_ALT  = 7'b0100000;
   localparam logic [6:0] F7_MULDIV = 7'b0000001;

   typedef enum logic [1:0] {
      QUAD0 = 2'b00,
      QUAD1 = 2'b01,
      QUAD2 = 2'b10,
      QUAD_FULL = 2'b11
   } quad_e;
endpackage

// File: rtl/insn_chk32.sv
module insn_chk32
   import insn_guard_pkg::*;
#(
   parameter bit ALLOW_MUL = 1'b1
) (
   input  logic [31:0] word,
   output logic        legal
);
   logic [6:0] opc;
   logic [2:0] f3;
   logic [6:0] f7;
   logic       mul_ok;
   logic       op_ok;
   logic       imm_ok;

   assign opc = word[6:0];
   assign f3  = word[14:12];
   assign f7  = word[31:25];

   generate
      if (ALLOW_MUL) begin : g_mul
         assign mul_ok = ~f3[2];
      end else begin : g_nomul
         assign mul_ok = 1'b0;
      end
   endgenerate

   always_comb begin
      unique case (f7)
         F7_BASE:   op_ok = 1'b1;
         F7_ALT:    op_ok = (f3 == 3'b000) || (f3 == 3'b101);
         F7_MULDIV: op_ok = mul_ok;
         default:   op_ok = 1'b0;
      endcase
   end

   always_comb begin
      unique case (f3)
         3'b001:  imm_ok = (f7 == F7_BASE);
         3'b101:  imm_ok = (f7 == F7_BASE) || (f7 == F7_ALT);
         default: imm_ok = 1'b1;
      endcase
   end

   always_comb begin
      unique case (opc)
         OPC_LUI, OPC_AUIPC, OPC_JAL: legal = 1'b1;
         OPC_JALR:   legal = (f3 == 3'b000);
         OPC_BRANCH: legal = (f3 != 3'b010) && (f3 != 3'b011);
         OPC_LOAD:   legal = (f3 != 3'b011) && (f3 != 3'b110) && (f3 != 3'b111);
         OPC_STORE:  legal = (f3 == 3'b000) || (f3 == 3'b001) || (f3 == 3'b010);
         OPC_OPIMM:  legal = imm_ok;
         OPC_OP:     legal = op_ok;
         default:    legal = 1'b0;
      endcase
   end
endmodule

// File: rtl/insn_chk16.sv
module insn_chk16
   import insn_guard_pkg::*;
(
   input  logic [15:0] half,
   output logic        legal
);
   logic [2:0] f3;
   logic [4:0] r_hi;
   logic [4:0] r_lo;
   logic       b12;

   assign f3   = half[15:13];
   assign r_hi = half[11:7];
   assign r_lo = half[6:2];
   assign b12  = half[12];

   always_comb begin
      legal = 1'b0;
      unique case (quad_e'(half[1:0]))
         QUAD0: begin
            unique case (f3)
               3'b000:         legal = (half[12:5] != 8'd0);
               3'b010, 3'b110: legal = 1'b1;
               default:        legal = 1'b0;
            endcase
         end
         QUAD1: begin
            unique case (f3)
               3'b011: legal = ({b12, r_lo} != 6'd0);
               3'b100: begin
                  unique case (half[11:10])
                     2'b00, 2'b01: legal = ~b12;
                     2'b10:        legal = 1'b1;
                     default:      legal = ~b12;
                  endcase
               end
               default: legal = 1'b1;
            endcase
         end
         QUAD2: begin
            unique case (f3)
               3'b000: legal = ~b12;
               3'b010: legal = (r_hi != 5'd0);
               3'b110: legal = 1'b1;
               3'b100: begin
                  if (!b12)
                     legal = (r_lo != 5'd0) || (r_hi != 5'd0);
                  else
                     legal = (r_lo != 5'd0) || (r_hi != 5'd0);
               end
               default: legal = 1'b0;
            endcase
         end
         default: legal = 1'b0;
      endcase
   end
endmodule

// File: rtl/insn_blink.sv
module insn_blink #(
   parameter int unsigned CNT_W = 21
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic phase
);
   localparam logic [CNT_W-1:0] CNT_TOP = '1;

   logic [CNT_W-1:0] cnt_q;
   logic             phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         phase_q <= 1'b1;
      end else if (!run) begin
         cnt_q   <= '0;
         phase_q <= 1'b1;
      end else begin
         cnt_q <= cnt_q + 1'b1;
         if (cnt_q == CNT_TOP)
            phase_q <= ~phase_q;
      end
   end

   assign phase = phase_q;

   // R11
   phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && cnt_q != CNT_TOP) |=> $stable(phase_q));
   // R11
   phase_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> phase_q);
endmodule

// File: rtl/insn_guard.sv
module insn_guard #(
   parameter bit          ALLOW_COMPRESSED = 1'b1,
   parameter bit          ALLOW_MUL        = 1'b1,
   parameter int unsigned BLINK_LOG2       = 21
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        insn_vld,
   input  logic [31:0] insn_word,
   output logic        halt,
   output logic        trap,
   output logic        led_r,
   output logic        led_g,
   output logic        led_b
);
   generate
      if (BLINK_LOG2 < 1 || BLINK_LOG2 > 30) begin : g_bad_blink
         $error("insn_guard: BLINK_LOG2 must lie in 1..30");
      end
   endgenerate

   logic is_short;
   logic ok32;
   logic ok16;
   logic illegal;
   logic halt_q;
   logic blink_on;

   assign is_short = (insn_word[1:0] != 2'b11);

   insn_chk32 #(.ALLOW_MUL(ALLOW_MUL)) u_chk32 (
      .word  (insn_word),
      .legal (ok32)
   );

   generate
      if (ALLOW_COMPRESSED) begin : g_rvc
         insn_chk16 u_chk16 (
            .half  (insn_word[15:0]),
            .legal (ok16)
         );
      end else begin : g_norvc
         assign ok16 = 1'b0;
      end
   endgenerate

   assign illegal = is_short ? ~ok16 : ~ok32;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         halt_q <= 1'b0;
      else if (insn_vld && illegal)
         halt_q <= 1'b1;
   end

   insn_blink #(.CNT_W(BLINK_LOG2)) u_blink (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (halt_q),
      .phase (blink_on)
   );

   assign halt  = halt_q;
   assign trap  = halt_q;
   assign led_r = halt_q & blink_on;
   assign led_g = ~halt_q;
   assign led_b = 1'b0;

   // R10
   halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halt |=> halt);
   // R9
   halt_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(halt) |-> $past(insn_vld && illegal));
   // R9
   legal_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!halt && !(insn_vld && illegal)) |=> !halt);
   // R11
   run_leds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !halt |-> (led_g && !led_r && !led_b));
   // R11
   halt_leds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(halt) |-> (led_r && !led_g));
endmodule

// File: tb/test_insn_guard.sv
module test_insn_guard;
   localparam int BL = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        insn_vld = 1'b0;
   logic [31:0] insn_word = 32'h0;
   logic        halt, trap, led_r, led_g, led_b;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   insn_guard #(.BLINK_LOG2(BL)) i_insn_guard (
      .clk(clk), .rst_n(rst_n), .insn_vld(insn_vld), .insn_word(insn_word),
      .halt(halt), .trap(trap), .led_r(led_r), .led_g(led_g), .led_b(led_b)
   );

   function automatic logic [31:0] rtype(input logic [6:0] f7, input logic [2:0] f3,
                                         input logic [6:0] opc);
      return {f7, 5'd2, 5'd1, f3, 5'd3, opc};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; insn_vld = 1'b0; insn_word = 32'h0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // present one word with valid high; returns at the first sample after the edge
   task automatic send(input logic [31:0] w);
      insn_word = w; insn_vld = 1'b1;
      @(negedge clk);
      insn_vld = 1'b0; insn_word = 32'h0;
   endtask

   task automatic t_reset_state();
      do_reset();
      check("R11 reset halt", {31'd0, halt}, 32'd0);
      check("R11 reset trap", {31'd0, trap}, 32'd0);
      check("R11 reset leds rgb", {29'd0, led_r, led_g, led_b}, 32'b010);
   endtask

   task automatic t_legal(input string req, input logic [31:0] w);
      send(w);
      check(req, {31'd0, halt}, 32'd0);
   endtask

   task automatic t_illegal(input string req, input logic [31:0] w);
      do_reset();
      send(w);
      check(req, {30'd0, halt, trap}, 32'b11);
   endtask

   task automatic t_no_strobe();
      do_reset();
      insn_word = 32'h0000_0073; insn_vld = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check("R9 strobe low ignored", {31'd0, halt}, 32'd0);
      insn_word = 32'h0;
   endtask

   task automatic t_sticky();
      do_reset();
      send(rtype(7'b0000001, 3'b100, 7'b0110011));
      for (int i = 0; i < 20; i++) send(rtype(7'b0, 3'b000, 7'b0110011));
      check("R10 sticky after legal traffic", {30'd0, halt, trap}, 32'b11);
      do_reset();
      check("R10 cleared by reset", {31'd0, halt}, 32'd0);
   endtask

   task automatic t_blink();
      do_reset();
      send(32'h0000_0000);
      for (int k = 0; k <= 16; k++) begin
         if (k == 0 || k == 7 || k == 16)
            check("R11 red on", {31'd0, led_r}, 32'd1);
         if (k == 8 || k == 15)
            check("R11 red off", {31'd0, led_r}, 32'd0);
         if (k == 0 || k == 12)
            check("R11 green blue off", {30'd0, led_g, led_b}, 32'd0);
         @(negedge clk);
      end
   endtask

   initial begin
      #200000;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      t_reset_state();
      // R1 base integer
      t_legal("R1 add", rtype(7'b0000000, 3'b000, 7'b0110011));
      t_legal("R1 sub", rtype(7'b0100000, 3'b000, 7'b0110011));
      t_legal("R1 srai", rtype(7'b0100000, 3'b101, 7'b0010011));
      t_legal("R1 lw", rtype(7'b0, 3'b010, 7'b0000011));
      t_legal("R1 sw", rtype(7'b0, 3'b010, 7'b0100011));
      t_legal("R1 bne", rtype(7'b0, 3'b001, 7'b1100011));
      t_legal("R1 jal", 32'h0040_006F);
      t_legal("R1 jalr", rtype(7'b0, 3'b000, 7'b1100111));
      t_legal("R1 lui", 32'h1234_50B7);
      t_legal("R1 auipc", 32'h0000_1097);
      // R2 multiply
      t_legal("R2 mul", rtype(7'b0000001, 3'b000, 7'b0110011));
      t_legal("R2 mulhu", rtype(7'b0000001, 3'b011, 7'b0110011));
      // R7 compressed, upper half ignored
      t_legal("R7 c.addi", 32'hFFFF_0505);
      t_legal("R7 c.lw", 32'h0073_4188);
      t_legal("R7 c.addi4spn", 32'h0000_0040);
      check("R7 still running", {30'd0, halt, led_g}, 32'b01);
      // illegal classes
      t_illegal("R3 div", rtype(7'b0000001, 3'b100, 7'b0110011));
      t_illegal("R3 remu", rtype(7'b0000001, 3'b111, 7'b0110011));
      t_illegal("R4 ecall", 32'h0000_0073);
      t_illegal("R4 csrrw", 32'h3000_1073);
      t_illegal("R5 fence", 32'h0FF0_000F);
      t_illegal("R5 fence.i", 32'h0000_100F);
      t_illegal("R6 flw", rtype(7'b0, 3'b010, 7'b0000111));
      t_illegal("R6 amo", rtype(7'b0, 3'b010, 7'b0101111));
      t_illegal("R8 zero half", 32'hFFFF_0000);
      t_illegal("R8 addi4spn zero imm", 32'h0000_0004);
      t_illegal("R8 c.ebreak", 32'h0000_9002);
      t_illegal("R8 c.fld", 32'h0000_2000);
      t_no_strobe();
      t_sticky();
      t_blink();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule